// File: doc/BRIEF.md
# Dual-Line GPIO Bank with Wakeup Request

A 32-pin general-purpose I/O bank sits behind a 32-bit register port that also accepts byte and halfword accesses. Software sets each pin's direction, drives data out through a full register or through set and clear aliases, and reads the sampled pin state. Pins that are inputs can raise events on a rising edge, a falling edge, a low level or a high level. Each kind of detection has its own per-pin select register, and any mix of the four may be enabled on a pin.

Every event is recorded in two independent status registers. Each status register is paired with its own enable register and drives one interrupt line, so two consumers can service the same pins under separate masks. When the configuration register enables wakeup and selects a nonzero idle mode, an event on a wake-enabled pin also raises a wakeup request. A configuration write with the reset bit set returns the bank to its reset state. The debounce enable and debounce time registers are stored and read back, but they do not filter anything.

Accesses are one cycle long. Writes commit at the clock edge. Read data is combinational from the address while `req_i` is high and `we_i` is low.

Top module: `gpio_dual_irq_bank`

## Requirements
- R1: After reset, reading returns the following. Revision (word 0x00) returns parameter REV_VAL. Sysstatus (0x14) returns 1. Output enable (0x34) returns all ones. Control (0x30) returns 2. Every other register returns 0, except data-out, which hardware reset sets to 0.
- R2: Size codes are 0 = byte, 1 = halfword, 2 = word. `addr_i[1:0]` selects the starting byte lane, and write data is aligned to bit 0. A sub-word write to a plain register changes only the addressed lanes. A sub-word read returns the addressed lanes shifted down to bit 0, with the upper bits zero.
- R3: The set aliases OR the written bits into their register and the clear aliases clear them. The aliases are line-1 enable (0x60 clear, 0x64 set), line-2 enable (0x70 clear, 0x74 set), wakeup enable (0x80 clear, 0x84 set) and data-out (0x90 clear, 0x94 set). Lanes not written count as zero. Reading an alias returns the underlying register.
- R4: Only pins whose output-enable bit is 1 (input mode) generate events. An event sets the pin's bit in both status registers (0x18 and 0x28), and the bit is visible from the next clock edge.
- R5: A rising event needs the pin's bit set in the rising register (0x48) and the pin going from 0 to 1. A falling event needs the pin's bit set in the falling register (0x4C) and the pin going from 1 to 0. A pin held steady does not create a new edge event.
- R6: Level detection (0x40 low, 0x44 high) raises an event in every cycle that an input pin sits at a selected level. Clearing the status bit while the level holds leaves the bit set. Switching a pin to input while it already sits at a selected level sets the bit.
- R7: Writing ones to a status register clears those bits in that register only. A new event in the same cycle wins over the clear. `irq_o[k]` is high while status k ANDed with enable k is nonzero. Enables are at 0x1C for line 1 and 0x2C for line 2.
- R8: `wake_o` is high in the cycle after an event on a pin whose wakeup-enable bit (0x20) is set. This happens only when sysconfig bit 2 is set and sysconfig bits 4:3 are nonzero.
- R9: Sysconfig (0x10) keeps only the bits in mask 0x1D. A write whose merged value has bit 1 set restores every register except data-out to its reset value, then stores the new value. A write whose merged bits 4:3 equal 3 pulses `idle_err_o` for one cycle.
- R10: Control keeps 3 bits and debounce time keeps 8 bits. Debounce enable keeps 32 bits. Writes to revision, sysstatus and data-in (0x38) have no effect. Unmapped offsets read 0.
- R11: `gpio_dout_o` follows the data-out register. `gpio_drive_o` is the inverse of output enable. Data-out survives a sysconfig soft reset. Data-in reads the pins as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset |
| size_i | input | 2 | Access size code |
| wdata_i | input | 32 | Write data, aligned to bit 0 |
| rdata_o | output | 32 | Read data, shifted to bit 0 |
| gpio_in_i | input | 32 | Pin input levels |
| gpio_dout_o | output | 32 | Pin output data |
| gpio_drive_o | output | 32 | Per-pin output driver enable |
| irq_o | output | 2 | Interrupt lines 1 and 2 |
| wake_o | output | 1 | Wakeup request |
| idle_err_o | output | 1 | Illegal idle-mode write pulse |

## Verification
The bench targets the lane merge on sub-word writes. A design that wrote the whole word would wipe the neighbouring bytes, and one that merged on the aliases would set or clear bits nobody wrote. It holds a pin high across a status clear, both on a level-detect pin and on an edge-detect pin. Treating both the same way either loses the level re-arm or keeps re-raising the edge interrupt. It also flips output enable while a pin already sits at a selected level, which catches a design that checks levels only on pin changes. Last, it walks the wakeup gating through each missing condition and checks that a soft reset leaves data-out alone.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
  localparam int unsigned REG_W = 32;

  // word indexes (byte offset >> 2)
  localparam logic [5:0] W_REV    = 6'h00;
  localparam logic [5:0] W_CFG    = 6'h04;
  localparam logic [5:0] W_SSTAT  = 6'h05;
  localparam logic [5:0] W_WKEN   = 6'h08;
  localparam logic [5:0] W_CTRL   = 6'h0C;
  localparam logic [5:0] W_OE     = 6'h0D;
  localparam logic [5:0] W_DIN    = 6'h0E;
  localparam logic [5:0] W_DOUT   = 6'h0F;
  localparam logic [5:0] W_LLO    = 6'h10;
  localparam logic [5:0] W_LHI    = 6'h11;
  localparam logic [5:0] W_RISE   = 6'h12;
  localparam logic [5:0] W_FALL   = 6'h13;
  localparam logic [5:0] W_DEBEN  = 6'h14;
  localparam logic [5:0] W_DEBT   = 6'h15;
  localparam logic [5:0] W_WK_CLR = 6'h20;
  localparam logic [5:0] W_WK_SET = 6'h21;
  localparam logic [5:0] W_DO_CLR = 6'h24;
  localparam logic [5:0] W_DO_SET = 6'h25;

  localparam logic [REG_W-1:0] CFG_KEEP  = 32'h0000_001D;
  localparam logic [2:0]       CTRL_RST  = 3'd2;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} acc_size_e;

  // per-line register indexes: line k sits 4 words above line k-1
  function automatic logic [5:0] st_idx(int k);
    return 6'(6 + 4 * k);
  endfunction
  function automatic logic [5:0] en_idx(int k);
    return 6'(7 + 4 * k);
  endfunction
  function automatic logic [5:0] enclr_idx(int k);
    return 6'(24 + 4 * k);
  endfunction
  function automatic logic [5:0] enset_idx(int k);
    return 6'(25 + 4 * k);
  endfunction

  function automatic logic [REG_W-1:0] lane_merge(logic [REG_W-1:0] cur,
                                                  logic [REG_W-1:0] wv,
                                                  logic [REG_W-1:0] lanes);
    return (cur & ~lanes) | (wv & lanes);
  endfunction
endpackage

// File: rtl/gpio_lane_ctrl.sv
`timescale 1ns/1ps
module gpio_lane_ctrl #(
  parameter int unsigned DW = 32,
  localparam int unsigned LW  = $clog2(DW / 8),
  localparam int unsigned SHW = $clog2(DW)
) (
  input  logic [LW-1:0] addr_lo_i,
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] rword_i,
  output logic [DW-1:0] lanes_o,
  output logic [DW-1:0] wval_o,
  output logic [DW-1:0] rdata_o
);
  import gpio_bank_pkg::*;

  logic [DW-1:0]  base;
  logic [SHW-1:0] sh;

  always_comb begin
    case (acc_size_e'(size_i))
      SZ_BYTE: base = DW'(8'hFF);
      SZ_HALF: base = DW'(16'hFFFF);
      default: base = '1;
    endcase
  end

  assign sh      = {addr_lo_i, 3'b000};
  assign lanes_o = base << sh;
  assign wval_o  = (wdata_i << sh) & lanes_o;
  assign rdata_o = (rword_i >> sh) & base;
endmodule

// File: rtl/gpio_edge_detect.sv
`timescale 1ns/1ps
module gpio_edge_detect #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] pin_q_i,
  input  logic [W-1:0] in_mode_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  output logic [W-1:0] evt_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise_ev, fall_ev, lvl_ev;
    assign rise_ev  = rise_i[i] & pin_i[i] & ~pin_q_i[i];
    assign fall_ev  = fall_i[i] & ~pin_i[i] & pin_q_i[i];
    assign lvl_ev   = (hi_i[i] & pin_i[i]) | (lo_i[i] & ~pin_i[i]);
    assign evt_o[i] = in_mode_i[i] & (rise_ev | fall_ev | lvl_ev);
  end
endmodule

// File: rtl/gpio_irq_line.sv
`timescale 1ns/1ps
module gpio_irq_line #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic [DW-1:0] evt_i,
  input  logic [DW-1:0] clr_i,
  input  logic          en_we_i,
  input  logic [DW-1:0] en_d_i,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] enable_o,
  output logic          irq_o
);
  logic [DW-1:0] st_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
      en_q <= '0;
    end else if (soft_rst_i) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      // a fresh event outranks a clear in the same cycle
      st_q <= (st_q & ~clr_i) | evt_i;
      if (en_we_i) en_q <= en_d_i;
    end
  end

  assign status_o = st_q;
  assign enable_o = en_q;
  assign irq_o    = |(st_q & en_q);
endmodule

// File: rtl/gpio_dual_irq_bank.sv
`timescale 1ns/1ps
module gpio_dual_irq_bank #(
  parameter logic [31:0] REV_VAL   = 32'h0000_0025,
  parameter int unsigned IRQ_LINES = 2,
  parameter int unsigned DEBT_W    = 8,
  parameter int unsigned CTRL_W    = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [1:0]  size_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic [31:0] gpio_in_i,
  output logic [31:0] gpio_dout_o,
  output logic [31:0] gpio_drive_o,
  output logic [1:0]  irq_o,
  output logic        wake_o,
  output logic        idle_err_o
);
  import gpio_bank_pkg::*;
  localparam int unsigned DW = REG_W;

  logic [5:0]    widx;
  logic          wr;
  logic [DW-1:0] lanes, wval, rword, rshift, cfg_new;
  logic          soft_rst, idle_bad;

  logic [DW-1:0]     cfg_q, oe_q, dout_q, llo_q, lhi_q, rise_q, fall_q, wken_q, deben_q, pin_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DEBT_W-1:0] debt_q;
  logic              wake_q, ierr_q;
  logic [DW-1:0]     evt;
  logic [DW-1:0]     st_w [IRQ_LINES];
  logic [DW-1:0]     en_w [IRQ_LINES];

  assign widx = addr_i[7:2];
  assign wr   = req_i & we_i;

  gpio_lane_ctrl #(.DW(DW)) u_lane (
    .addr_lo_i (addr_i[1:0]),
    .size_i    (size_i),
    .wdata_i   (wdata_i),
    .rword_i   (rword),
    .lanes_o   (lanes),
    .wval_o    (wval),
    .rdata_o   (rshift)
  );

  assign cfg_new  = lane_merge(cfg_q, wval, lanes);
  assign soft_rst = wr && (widx == W_CFG) && cfg_new[1];
  assign idle_bad = wr && (widx == W_CFG) && (cfg_new[4:3] == 2'b11);

  gpio_edge_detect #(.W(DW)) u_det (
    .pin_i     (gpio_in_i),
    .pin_q_i   (pin_q),
    .in_mode_i (oe_q),
    .lo_i      (llo_q),
    .hi_i      (lhi_q),
    .rise_i    (rise_q),
    .fall_i    (fall_q),
    .evt_o     (evt)
  );

  for (genvar k = 0; k < IRQ_LINES; k++) begin : g_line
    logic          en_we;
    logic [DW-1:0] en_d, clr;

    always_comb begin
      en_we = 1'b0;
      en_d  = en_w[k];
      clr   = '0;
      if (wr) begin
        if (widx == st_idx(k)) clr = wval;
        if (widx == en_idx(k)) begin
          en_we = 1'b1;
          en_d  = lane_merge(en_w[k], wval, lanes);
        end
        if (widx == enclr_idx(k)) begin
          en_we = 1'b1;
          en_d  = en_w[k] & ~wval;
        end
        if (widx == enset_idx(k)) begin
          en_we = 1'b1;
          en_d  = en_w[k] | wval;
        end
      end
    end

    gpio_irq_line #(.DW(DW)) u_line (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .soft_rst_i (soft_rst),
      .evt_i      (evt),
      .clr_i      (clr),
      .en_we_i    (en_we),
      .en_d_i     (en_d),
      .status_o   (st_w[k]),
      .enable_o   (en_w[k]),
      .irq_o      (irq_o[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      ctrl_q  <= CTRL_RST;
      oe_q    <= '1;
      dout_q  <= '0;
      llo_q   <= '0;
      lhi_q   <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      wken_q  <= '0;
      deben_q <= '0;
      debt_q  <= '0;
    end else if (soft_rst) begin
      cfg_q   <= cfg_new & CFG_KEEP;
      ctrl_q  <= CTRL_RST;
      oe_q    <= '1;
      llo_q   <= '0;
      lhi_q   <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      wken_q  <= '0;
      deben_q <= '0;
      debt_q  <= '0;
    end else if (wr) begin
      case (widx)
        W_CFG:    cfg_q   <= cfg_new & CFG_KEEP;
        W_CTRL:   ctrl_q  <= CTRL_W'(lane_merge(DW'(ctrl_q), wval, lanes));
        W_OE:     oe_q    <= lane_merge(oe_q, wval, lanes);
        W_DOUT:   dout_q  <= lane_merge(dout_q, wval, lanes);
        W_DO_CLR: dout_q  <= dout_q & ~wval;
        W_DO_SET: dout_q  <= dout_q | wval;
        W_LLO:    llo_q   <= lane_merge(llo_q, wval, lanes);
        W_LHI:    lhi_q   <= lane_merge(lhi_q, wval, lanes);
        W_RISE:   rise_q  <= lane_merge(rise_q, wval, lanes);
        W_FALL:   fall_q  <= lane_merge(fall_q, wval, lanes);
        W_WKEN:   wken_q  <= lane_merge(wken_q, wval, lanes);
        W_WK_CLR: wken_q  <= wken_q & ~wval;
        W_WK_SET: wken_q  <= wken_q | wval;
        W_DEBEN:  deben_q <= lane_merge(deben_q, wval, lanes);
        W_DEBT:   debt_q  <= DEBT_W'(lane_merge(DW'(debt_q), wval, lanes));
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q  <= '0;
      wake_q <= 1'b0;
      ierr_q <= 1'b0;
    end else begin
      pin_q  <= gpio_in_i;
      wake_q <= (|(evt & wken_q)) & cfg_q[2] & (|cfg_q[4:3]);
      ierr_q <= idle_bad;
    end
  end

  always_comb begin
    rword = '0;
    case (widx)
      W_REV:                      rword = REV_VAL;
      W_CFG:                      rword = cfg_q;
      W_SSTAT:                    rword = DW'(1);
      W_WKEN, W_WK_CLR, W_WK_SET: rword = wken_q;
      W_CTRL:                     rword = DW'(ctrl_q);
      W_OE:                       rword = oe_q;
      W_DIN:                      rword = pin_q;
      W_DOUT, W_DO_CLR, W_DO_SET: rword = dout_q;
      W_LLO:                      rword = llo_q;
      W_LHI:                      rword = lhi_q;
      W_RISE:                     rword = rise_q;
      W_FALL:                     rword = fall_q;
      W_DEBEN:                    rword = deben_q;
      W_DEBT:                     rword = DW'(debt_q);
      default: ;
    endcase
    for (int k = 0; k < IRQ_LINES; k++) begin
      if (widx == st_idx(k)) rword = st_w[k];
      if (widx == en_idx(k) || widx == enclr_idx(k) || widx == enset_idx(k)) rword = en_w[k];
    end
  end

  assign rdata_o      = (req_i && !we_i) ? rshift : '0;
  assign gpio_dout_o  = dout_q;
  assign gpio_drive_o = ~oe_q;
  assign wake_o       = wake_q;
  assign idle_err_o   = ierr_q;
endmodule

// File: rtl/gpio_dual_irq_bank_chk.sv
`timescale 1ns/1ps
module gpio_dual_irq_bank_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [7:0]  addr_i,
  input logic [1:0]  size_i,
  input logic [31:0] rdata_o,
  input logic        wake_o,
  input logic        idle_err_o,
  input logic        irq0_i,
  input logic        en_any0_i,
  input logic        pin0_i,
  input logic        oe0_i,
  input logic        lhi0_i,
  input logic        st0_i,
  input logic [2:0]  cfg_i,
  input logic        soft_i
);
  // R1: sysstatus word read is always 1
  a_r1_sysstatus_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == 8'h14 && size_i == 2'd2) |-> rdata_o == 32'h1);

  // R10: unmapped word reads zero
  a_r10_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[7:2] == 6'h3F) |-> rdata_o == 32'h0);

  // R4: an output pin never raises its status bit
  a_r4_output_no_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe0_i && !st0_i) |=> !st0_i);

  // R6: a held high level keeps status set
  a_r6_level_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!soft_i && oe0_i && lhi0_i && pin0_i) |=> st0_i);

  // R7: interrupt needs an enable bit
  a_r7_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq0_i |-> en_any0_i);

  // R8: wakeup only under enabled config
  a_r8_wake_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(cfg_i[0] && cfg_i[2:1] != 2'b00));

  // R9: idle error follows a config write
  a_r9_idle_err_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_err_o |-> $past(req_i && we_i && addr_i[7:2] == 6'h04));
endmodule

bind gpio_dual_irq_bank gpio_dual_irq_bank_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .size_i     (size_i),
  .rdata_o    (rdata_o),
  .wake_o     (wake_o),
  .idle_err_o (idle_err_o),
  .irq0_i     (irq_o[0]),
  .en_any0_i  (|en_w[0]),
  .pin0_i     (gpio_in_i[0]),
  .oe0_i      (oe_q[0]),
  .lhi0_i     (lhi_q[0]),
  .st0_i      (st_w[0][0]),
  .cfg_i      (cfg_q[4:2]),
  .soft_i     (soft_rst)
);

// File: tb/gpio_dual_irq_bank_tb.sv
`timescale 1ns/1ps
module gpio_dual_irq_bank_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [1:0]  size = 2'd2;
  logic [31:0] wdata = '0, rdata, pins = '0, dout, drive;
  logic [1:0]  irq;
  logic        wake, ierr;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  gpio_dual_irq_bank u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .gpio_in_i(pins),
    .gpio_dout_o(dout), .gpio_drive_o(drive), .irq_o(irq), .wake_o(wake),
    .idle_err_o(ierr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; size = s; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [1:0] s, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; size = s;
    #5;
    chk(rdata === exp, tag, rdata, exp);
    req = 1'b0;
  endtask

  task automatic set_pins(input logic [31:0] v);
    @(negedge clk);
    pins = v;
  endtask

  // {req tag, write, addr, size, data, expected read}
  localparam int NV = 55;
  localparam logic [78:0] VEC [NV] = '{
    {4'd1, 1'b0, 8'h00, 2'd2, 32'h0, 32'h0000_0025},   // R1 revision
    {4'd1, 1'b0, 8'h14, 2'd2, 32'h0, 32'h0000_0001},   // R1 sysstatus
    {4'd1, 1'b0, 8'h34, 2'd2, 32'h0, 32'hFFFF_FFFF},   // R1 oe reset
    {4'd1, 1'b0, 8'h30, 2'd2, 32'h0, 32'h0000_0002},   // R1 ctrl reset
    {4'd1, 1'b0, 8'h10, 2'd2, 32'h0, 32'h0},
    {4'd1, 1'b1, 8'h40, 2'd2, 32'h1234_5678, 32'h0},
    {4'd1, 1'b0, 8'h40, 2'd2, 32'h0, 32'h1234_5678},
    {4'd2, 1'b1, 8'h41, 2'd0, 32'h0000_00AB, 32'h0},   // R2 byte lane 1
    {4'd2, 1'b0, 8'h40, 2'd2, 32'h0, 32'h1234_AB78},
    {4'd2, 1'b1, 8'h42, 2'd1, 32'h0000_CDEF, 32'h0},   // R2 upper half
    {4'd2, 1'b0, 8'h40, 2'd2, 32'h0, 32'hCDEF_AB78},
    {4'd2, 1'b0, 8'h42, 2'd1, 32'h0, 32'h0000_CDEF},
    {4'd2, 1'b0, 8'h41, 2'd0, 32'h0, 32'h0000_00AB},
    {4'd2, 1'b1, 8'h40, 2'd2, 32'h0, 32'h0},
    {4'd3, 1'b1, 8'h1C, 2'd2, 32'h0000_00F0, 32'h0},   // R3 enable aliases
    {4'd3, 1'b1, 8'h64, 2'd0, 32'h0000_000F, 32'h0},
    {4'd3, 1'b0, 8'h1C, 2'd2, 32'h0, 32'h0000_00FF},
    {4'd3, 1'b0, 8'h60, 2'd2, 32'h0, 32'h0000_00FF},
    {4'd3, 1'b1, 8'h60, 2'd0, 32'h0000_0003, 32'h0},
    {4'd3, 1'b0, 8'h64, 2'd2, 32'h0, 32'h0000_00FC},
    {4'd3, 1'b1, 8'h3C, 2'd2, 32'hFFFF_0000, 32'h0},   // R3 data-out aliases
    {4'd3, 1'b1, 8'h92, 2'd1, 32'h0000_00FF, 32'h0},
    {4'd3, 1'b1, 8'h94, 2'd0, 32'h0000_005A, 32'h0},
    {4'd3, 1'b0, 8'h90, 2'd2, 32'h0, 32'hFF00_005A},
    {4'd3, 1'b1, 8'h84, 2'd2, 32'h0000_0011, 32'h0},   // R3 wake aliases
    {4'd3, 1'b1, 8'h80, 2'd2, 32'h0000_0001, 32'h0},
    {4'd3, 1'b0, 8'h20, 2'd2, 32'h0, 32'h0000_0010},
    {4'd3, 1'b1, 8'h2C, 2'd2, 32'h0000_0003, 32'h0},
    {4'd3, 1'b1, 8'h74, 2'd2, 32'h0000_0004, 32'h0},
    {4'd3, 1'b1, 8'h70, 2'd2, 32'h0000_0001, 32'h0},
    {4'd3, 1'b0, 8'h2C, 2'd2, 32'h0, 32'h0000_0006},
    {4'd10, 1'b1, 8'h30, 2'd2, 32'h0000_00FF, 32'h0},  // R10 widths
    {4'd10, 1'b0, 8'h30, 2'd2, 32'h0, 32'h0000_0007},
    {4'd10, 1'b1, 8'h54, 2'd2, 32'h0000_01FF, 32'h0},
    {4'd10, 1'b0, 8'h54, 2'd2, 32'h0, 32'h0000_00FF},
    {4'd10, 1'b1, 8'h50, 2'd2, 32'hA5A5_A5A5, 32'h0},
    {4'd10, 1'b0, 8'h50, 2'd2, 32'h0, 32'hA5A5_A5A5},
    {4'd10, 1'b1, 8'h00, 2'd2, 32'h0000_FFFF, 32'h0},  // R10 read-only
    {4'd10, 1'b0, 8'h00, 2'd2, 32'h0, 32'h0000_0025},
    {4'd10, 1'b1, 8'h14, 2'd2, 32'h0, 32'h0},
    {4'd10, 1'b0, 8'h14, 2'd2, 32'h0, 32'h0000_0001},
    {4'd10, 1'b0, 8'h58, 2'd2, 32'h0, 32'h0},
    {4'd10, 1'b0, 8'hFC, 2'd2, 32'h0, 32'h0},
    {4'd9, 1'b1, 8'h10, 2'd2, 32'h0000_003D, 32'h0},   // R9 keep mask
    {4'd9, 1'b0, 8'h10, 2'd2, 32'h0, 32'h0000_001D},
    {4'd9, 1'b1, 8'h11, 2'd0, 32'h0000_0000, 32'h0},
    {4'd9, 1'b0, 8'h10, 2'd2, 32'h0, 32'h0000_001D},
    {4'd9, 1'b1, 8'h10, 2'd0, 32'h0000_0002, 32'h0},   // R9 soft reset
    {4'd9, 1'b0, 8'h10, 2'd2, 32'h0, 32'h0},
    {4'd9, 1'b0, 8'h1C, 2'd2, 32'h0, 32'h0},
    {4'd9, 1'b0, 8'h2C, 2'd2, 32'h0, 32'h0},
    {4'd9, 1'b0, 8'h20, 2'd2, 32'h0, 32'h0},
    {4'd9, 1'b0, 8'h30, 2'd2, 32'h0, 32'h0000_0002},
    {4'd9, 1'b0, 8'h54, 2'd2, 32'h0, 32'h0},
    {4'd11, 1'b0, 8'h3C, 2'd2, 32'h0, 32'hFF00_005A}   // R11 survives soft reset
  };

  initial begin
    #25;
    rst_ni = 1'b1;
    @(negedge clk);
    chk(irq === 2'b00, "R1 irq reset", {30'b0, irq}, 32'h0);
    chk(wake === 1'b0, "R1 wake reset", {31'b0, wake}, 32'h0);
    chk(ierr === 1'b0, "R1 idle_err reset", {31'b0, ierr}, 32'h0);
    chk(dout === 32'h0, "R1 dout reset", dout, 32'h0);
    chk(drive === 32'h0, "R11 drive reset", drive, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][74])
        wr(VEC[i][73:66], VEC[i][65:64], VEC[i][63:32]);
      else
        rd(VEC[i][73:66], VEC[i][65:64], VEC[i][31:0], $sformatf("R%0d vec %0d", VEC[i][78:75], i));
    end
    chk(dout === 32'hFF00_005A, "R11 dout pins", dout, 32'hFF00_005A);

    // R5 rising edge, R4 both status regs, R7 per-line clear
    wr(8'h48, 2'd2, 32'h1);
    wr(8'h1C, 2'd2, 32'h1);
    set_pins(32'h1);
    @(negedge clk);
    chk(irq === 2'b01, "R7 irq line1 only", {30'b0, irq}, 32'h1);
    rd(8'h28, 2'd2, 32'h1, "R4 line2 status set");
    wr(8'h18, 2'd2, 32'h1);
    chk(irq[0] === 1'b0, "R7 irq drops after clear", {31'b0, irq[0]}, 32'h0);
    rd(8'h18, 2'd2, 32'h0, "R5 held high no new edge");
    rd(8'h28, 2'd2, 32'h1, "R7 line2 unaffected");
    set_pins(32'h0);
    rd(8'h18, 2'd2, 32'h0, "R5 falling not selected");
    wr(8'h4C, 2'd2, 32'h1);
    set_pins(32'h1);
    wr(8'h18, 2'd2, 32'h1);
    set_pins(32'h0);
    rd(8'h18, 2'd2, 32'h1, "R5 falling edge");
    wr(8'h18, 2'd2, 32'hFFFF_FFFF);
    wr(8'h28, 2'd2, 32'hFFFF_FFFF);

    // R4 output pins ignored
    wr(8'h34, 2'd2, 32'hFFFF_FFFE);
    chk(drive === 32'h1, "R11 drive follows oe", drive, 32'h1);
    set_pins(32'h1);
    set_pins(32'h0);
    rd(8'h18, 2'd2, 32'h0, "R4 output pin no event");
    wr(8'h34, 2'd2, 32'hFFFF_FFFF);
    wr(8'h48, 2'd2, 32'h0);
    wr(8'h4C, 2'd2, 32'h0);

    // R6 level high re-arm
    wr(8'h44, 2'd2, 32'h2);
    set_pins(32'h2);
    rd(8'h18, 2'd2, 32'h2, "R6 level high sets");
    wr(8'h18, 2'd2, 32'h2);
    rd(8'h18, 2'd2, 32'h2, "R6 re-armed after clear");
    set_pins(32'h0);
    wr(8'h18, 2'd2, 32'hFFFF_FFFF);
    wr(8'h28, 2'd2, 32'hFFFF_FFFF);
    rd(8'h18, 2'd2, 32'h0, "R6 clears when level gone");
    wr(8'h34, 2'd2, 32'hFFFF_FFFD);
    set_pins(32'h2);
    rd(8'h18, 2'd2, 32'h0, "R4 level on output pin ignored");
    wr(8'h34, 2'd2, 32'hFFFF_FFFF);
    rd(8'h18, 2'd2, 32'h2, "R6 oe change rechecks level");
    wr(8'h44, 2'd2, 32'h0);
    set_pins(32'h0);
    wr(8'h18, 2'd2, 32'hFFFF_FFFF);
    wr(8'h28, 2'd2, 32'hFFFF_FFFF);

    // R6 level low
    wr(8'h40, 2'd2, 32'h4);
    rd(8'h18, 2'd2, 32'h4, "R6 level low sets");
    wr(8'h40, 2'd2, 32'h0);
    wr(8'h18, 2'd2, 32'hFFFF_FFFF);
    wr(8'h28, 2'd2, 32'hFFFF_FFFF);

    // R11 data-in, R10 read-only
    set_pins(32'hA500_0000);
    rd(8'h38, 2'd2, 32'hA500_0000, "R11 data-in sample");
    wr(8'h38, 2'd2, 32'h0);
    rd(8'h38, 2'd2, 32'hA500_0000, "R10 data-in read-only");
    set_pins(32'h0);

    // R8 wakeup gating
    wr(8'h20, 2'd2, 32'h8);
    wr(8'h48, 2'd2, 32'h8);
    set_pins(32'h8);
    @(negedge clk);
    chk(wake === 1'b0, "R8 no wake cfg off", {31'b0, wake}, 32'h0);
    set_pins(32'h0);
    wr(8'h10, 2'd2, 32'h4);
    set_pins(32'h8);
    @(negedge clk);
    chk(wake === 1'b0, "R8 no wake idle zero", {31'b0, wake}, 32'h0);
    set_pins(32'h0);
    wr(8'h10, 2'd2, 32'hC);
    set_pins(32'h8);
    @(negedge clk);
    chk(wake === 1'b1, "R8 wake raised", {31'b0, wake}, 32'h1);
    @(negedge clk);
    chk(wake === 1'b0, "R8 wake one cycle", {31'b0, wake}, 32'h0);
    set_pins(32'h0);
    wr(8'h80, 2'd2, 32'h8);
    set_pins(32'h8);
    @(negedge clk);
    chk(wake === 1'b0, "R8 no wake pin disabled", {31'b0, wake}, 32'h0);
    set_pins(32'h0);
    wr(8'h48, 2'd2, 32'h0);
    wr(8'h18, 2'd2, 32'hFFFF_FFFF);
    wr(8'h28, 2'd2, 32'hFFFF_FFFF);

    // R9 illegal idle mode
    wr(8'h10, 2'd2, 32'h18);
    chk(ierr === 1'b1, "R9 idle_err pulse", {31'b0, ierr}, 32'h1);
    @(negedge clk);
    chk(ierr === 1'b0, "R9 idle_err one cycle", {31'b0, ierr}, 32'h0);
    rd(8'h10, 2'd2, 32'h18, "R9 cfg stored");
    wr(8'h10, 2'd2, 32'h08);
    chk(ierr === 1'b0, "R9 legal idle no flag", {31'b0, ierr}, 32'h0);
    wr(8'h10, 2'd2, 32'h0);

    // R7 both lines enabled, independent clear
    wr(8'h2C, 2'd2, 32'h1);
    wr(8'h48, 2'd2, 32'h1);
    set_pins(32'h1);
    @(negedge clk);
    chk(irq === 2'b11, "R7 both lines", {30'b0, irq}, 32'h3);
    wr(8'h28, 2'd2, 32'h1);
    chk(irq === 2'b01, "R7 line2 cleared only", {30'b0, irq}, 32'h1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 50000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all-requirements actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule